// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when a chip leaves its low-power states (Sleep and Stop) and records why it did. It watches a set of external wake lines, a transceiver wake pulse and an internal dwell timer. Configuration arrives through a small register write port. One field sets the level sensitivity of each pair of wake lines. A 4-bit control field selects how the lines are sensed (continuously, or only while a periodically pulsed bias switch is on) and enables timed forced wake-up and transceiver wake-up.

The controller finds out whether the chip is in low power from a 2-bit mode input: 00 Normal, 01 Standby, 10 Sleep, 11 Stop. It treats the first cycle with mode bit 1 set as the entry cycle. On entry it clears its wake record and restarts its timers. The first qualifying event after entry latches the cause. A wake from Sleep then raises the supply enable and a wake from Stop raises the interrupt. Both outputs stay up until the next entry into low power. The cause record is frozen until that next entry.

Top module: `lp_wake_ctrl`

## Requirements
- R1: `line_state_o` shows `wake_lines_i` one cycle late, in every mode.
- R2: Sensitivity is set per pair. Lines 0 and 1 use `sens_cfg_o[1:0]` and lines 2 and 3 use `sens_cfg_o[3:0]` bits [3:2]. The codes are 00 off, 01 line high, 10 line low and 11 line differs from its value in the last cycle before entry.
- R3: Control bits 3 and 0 both at 0 select direct sensing. In this mode every cycle in low power after the entry cycle evaluates the lines.
- R4: Control bits 3 and 0 both at 1 select cyclic sensing. Cycles after entry are counted from 0, modulo `CYC_PERIOD`. `bias_en_o` is high when the count is below `BIAS_ON`, while in low power and not yet woken. Lines are evaluated only at count `BIAS_ON-1`, and line activity on any other cycle is ignored.
- R5: When exactly one of control bits 3 and 0 is set, the lines never cause a wake.
- R6: A write to the control field is discarded when the written value has bits 3, 1 and 0 all set. This keeps forced wake (bit 1) and cyclic sensing mutually exclusive in both directions.
- R7: With control bit 1 set, the block wakes at cycle `FWU_TIME-1` after entry and sets `timer_wake_o`.
- R8: With control bit 2 set, a high `xcvr_wake_i` in low power after the entry cycle wakes the block and sets `xcvr_wake_o`. With bit 2 clear, the pulse is ignored.
- R9: A wake in Sleep sets `supply_en_o` and a wake in Stop sets `irq_o`. The two are never high together, and both clear on the next entry.
- R10: `wake_src_o` latches the lines that matched at the wake (0 when no line caused it). The first wake freezes the record until the next entry, which clears it.
- R11: Writes with mode 10 or 11 are ignored. `cfg_sel_i` = 0 writes the sensitivity field and 1 writes the control field.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 00 Normal, 01 Standby, 10 Sleep, 11 Stop |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 sensitivity field, 1 control field |
| cfg_wdata_i | input | CFG_W (4) | Write data |
| wake_lines_i | input | NUM_LINES (4) | Digitised wake lines |
| xcvr_wake_i | input | 1 | Wake pulse from the transceiver detector |
| line_state_o | output | NUM_LINES (4) | Registered line state |
| sens_cfg_o | output | SENS_W (4) | Current sensitivity field |
| lp_cfg_o | output | 4 | Current control field |
| bias_en_o | output | 1 | Bias switch enable for cyclic sensing |
| supply_en_o | output | 1 | Main supply enable after a Sleep wake |
| irq_o | output | 1 | Interrupt after a Stop wake |
| wake_src_o | output | NUM_LINES (4) | Lines that caused the wake |
| timer_wake_o | output | 1 | Wake came from the dwell timer |
| xcvr_wake_o | output | 1 | Wake came from the transceiver |

## Verification
Suppose the cyclic counter drifts or misses a wrap. The `bias_en_o` pattern at the port then goes wrong within one period, and line edges placed around the sample slot wake the block one slot early or late. A snapshot taken at the wrong time, or a flag that is not cleared on entry, appears in `wake_src_o` at the first wake after the next entry. A wrong record of the mode at wake time flips the supply and interrupt outputs on the cycle after the event. The bench's cycle model compares every output on every cycle, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/lpw_pkg.sv
// Shared types and helpers for the low-power wake-up controller.
// Assumes the mode encoding 00 Normal, 01 Standby, 10 Sleep, 11 Stop,
// so bit 1 alone marks a low-power state.
package lpw_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_STANDBY = 2'b01,
        MODE_SLEEP   = 2'b10,
        MODE_STOP    = 2'b11
    } lp_mode_e;

    localparam int LPC_W        = 4;
    localparam int LPC_AUTO_BIT = 0;   // automatic bias switching
    localparam int LPC_FWU_BIT  = 1;   // timed forced wake
    localparam int LPC_XCVR_BIT = 2;   // transceiver wake enable
    localparam int LPC_BIAS_BIT = 3;   // bias routed to the wake lines

    localparam logic [1:0] SENS_OFF  = 2'b00;
    localparam logic [1:0] SENS_HIGH = 2'b01;
    localparam logic [1:0] SENS_LOW  = 2'b10;
    localparam logic [1:0] SENS_EDGE = 2'b11;

    // Decide whether one line meets its pair's sensitivity code.
    function automatic logic sens_match(input logic [1:0] code,
                                        input logic cur, input logic snap);
        case (code)
            SENS_HIGH: return cur;
            SENS_LOW:  return !cur;
            SENS_EDGE: return cur != snap;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lpw_cfg_regs.sv
// Holds the sensitivity and control fields. Writes are accepted only
// outside low power, and a control write that would enable cyclic
// sensing together with forced wake is dropped whole.
module lpw_cfg_regs
    import lpw_pkg::*;
#(
    parameter int SENS_W = 4,
    parameter int CFG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_i,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic [SENS_W-1:0] sens_o,
    output logic [LPC_W-1:0]  lpc_o
);

    logic [SENS_W-1:0] sens_q;
    logic [LPC_W-1:0]  lpc_q;
    logic              both_req;

    // Flag a control value asking for cyclic and forced wake together.
    assign both_req = wdata_i[LPC_BIAS_BIT] && wdata_i[LPC_AUTO_BIT]
                   && wdata_i[LPC_FWU_BIT];

    // Register writes, gated by mode and by the exclusion rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sens_q <= '0;
            lpc_q  <= '0;
        end else if (we_i && !lp_i) begin
            if (!sel_i)
                sens_q <= wdata_i[SENS_W-1:0];
            else if (!both_req)
                lpc_q <= wdata_i[LPC_W-1:0];
        end
    end

    assign sens_o = sens_q;
    assign lpc_o  = lpc_q;

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lp_i |=> ($stable(sens_q) && $stable(lpc_q)))
        else $error("configuration changed during low power");

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lpc_q[LPC_BIAS_BIT] && lpc_q[LPC_AUTO_BIT] && lpc_q[LPC_FWU_BIT]))
        else $error("cyclic sensing and forced wake both enabled");

endmodule

// File: rtl/lpw_timers.sv
// Cyclic-sense frame counter and forced-wake dwell counter. Both hold at
// zero outside low power, so count 0 falls on the entry cycle.
// Assumes 2 <= BIAS_ON <= CYC_PERIOD and FWU_TIME >= 2.
module lpw_timers #(
    parameter int CYC_PERIOD = 16,
    parameter int BIAS_ON    = 4,
    parameter int FWU_TIME   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    output logic bias_win_o,
    output logic sample_o,
    output logic fwu_due_o
);

    localparam int CW = $clog2(CYC_PERIOD + 1);
    localparam int FW = $clog2(FWU_TIME + 1);

    logic [CW-1:0] cyc_cnt;
    logic [FW-1:0] fwu_cnt;

    // Frame counter: wraps every CYC_PERIOD cycles while in low power.
    always_ff @(posedge clk) begin
        if (!rst_n || !lp_i)
            cyc_cnt <= '0;
        else if (cyc_cnt == CW'(CYC_PERIOD - 1))
            cyc_cnt <= '0;
        else
            cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Dwell counter: saturates on the forced-wake cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !lp_i)
            fwu_cnt <= '0;
        else if (fwu_cnt != FW'(FWU_TIME - 1))
            fwu_cnt <= fwu_cnt + 1'b1;
    end

    assign bias_win_o = lp_i && (cyc_cnt < CW'(BIAS_ON));
    assign sample_o   = lp_i && (cyc_cnt == CW'(BIAS_ON - 1));
    assign fwu_due_o  = lp_i && (fwu_cnt == FW'(FWU_TIME - 1));

    assert_cyc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt == CW'(CYC_PERIOD - 1)) |=> (cyc_cnt == '0))
        else $error("cyclic frame counter did not wrap");

    assert_fwu_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fwu_due_o |=> $stable(fwu_cnt))
        else $error("dwell counter moved past its limit");

endmodule

// File: rtl/lpw_wake_core.sv
// Evaluates the wake sources and latches the first wake after entry.
// Assumes the timers report sample and dwell events for the current
// cycle. Entry (first cycle in low power) clears the record and
// evaluates nothing.
module lpw_wake_core
    import lpw_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic                 xcvr_i,
    input  logic [NUM_LINES-1:0] sens_i,
    input  logic [LPC_W-1:0]     lpc_i,
    input  logic                 sample_i,
    input  logic                 fwu_due_i,
    output logic                 woken_o,
    output logic [NUM_LINES-1:0] wake_src_o,
    output logic                 timer_o,
    output logic                 xcvr_o,
    output logic                 supply_o,
    output logic                 irq_o
);

    logic                 lp, lp_q, woken_q, timer_q, xcvr_q, sup_q, irq_q;
    logic [NUM_LINES-1:0] snap_q, match, src_q;
    logic                 direct, cyclic, eval, line_hit, timer_hit, xcvr_hit;

    assign lp = mode_i[1];

    // Per-line sensitivity test, each line using its pair's code.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign match[g] = sens_match(sens_i[2*(g/2) +: 2], lines_i[g], snap_q[g]);
    end

    // Decode the sensing mode and the qualified wake sources.
    always_comb begin
        direct    = !lpc_i[LPC_BIAS_BIT] && !lpc_i[LPC_AUTO_BIT];
        cyclic    = lpc_i[LPC_BIAS_BIT] && lpc_i[LPC_AUTO_BIT];
        eval      = lp && lp_q && !woken_q;
        line_hit  = eval && (|match) && (direct || (cyclic && sample_i));
        timer_hit = eval && lpc_i[LPC_FWU_BIT] && fwu_due_i;
        xcvr_hit  = eval && lpc_i[LPC_XCVR_BIT] && xcvr_i;
    end

    // Track the low-power state and snapshot the lines before entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q   <= 1'b0;
            snap_q <= '0;
        end else begin
            lp_q <= lp;
            if (!lp)
                snap_q <= lines_i;
        end
    end

    // Clear the record on entry; latch cause and response on first wake.
    always_ff @(posedge clk) begin
        if (!rst_n || (lp && !lp_q)) begin
            woken_q <= 1'b0;
            src_q   <= '0;
            timer_q <= 1'b0;
            xcvr_q  <= 1'b0;
            sup_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else if (line_hit || timer_hit || xcvr_hit) begin
            woken_q <= 1'b1;
            src_q   <= line_hit ? match : '0;
            timer_q <= timer_hit;
            xcvr_q  <= xcvr_hit;
            sup_q   <= (mode_i == MODE_SLEEP);
            irq_q   <= (mode_i == MODE_STOP);
        end
    end

    assign woken_o    = woken_q;
    assign wake_src_o = src_q;
    assign timer_o    = timer_q;
    assign xcvr_o     = xcvr_q;
    assign supply_o   = sup_q;
    assign irq_o      = irq_q;

    assert_single_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sup_q && irq_q))
        else $error("supply enable and interrupt raised together");

    assert_record_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (woken_q && lp_q && lp) |=> $stable(src_q))
        else $error("wake record changed after the first wake");

    assert_timer_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_q) |-> $past(lpc_i[LPC_FWU_BIT]))
        else $error("timer wake without forced-wake enable");

endmodule

// File: rtl/lp_wake_ctrl.sv
// Top of the low-power wake-up controller: configuration registers,
// cyclic and dwell timers, and the wake evaluation core. Lines are
// assumed already digitised and synchronous to clk.
module lp_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int NUM_PAIRS  = 2,
    parameter int CYC_PERIOD = 16,
    parameter int BIAS_ON    = 4,
    parameter int FWU_TIME   = 40,
    localparam int NUM_LINES = 2 * NUM_PAIRS,
    localparam int SENS_W    = 2 * NUM_PAIRS,
    localparam int CFG_W     = (SENS_W > LPC_W) ? SENS_W : LPC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_sel_i,
    input  logic [CFG_W-1:0]     cfg_wdata_i,
    input  logic [NUM_LINES-1:0] wake_lines_i,
    input  logic                 xcvr_wake_i,
    output logic [NUM_LINES-1:0] line_state_o,
    output logic [SENS_W-1:0]    sens_cfg_o,
    output logic [LPC_W-1:0]     lp_cfg_o,
    output logic                 bias_en_o,
    output logic                 supply_en_o,
    output logic                 irq_o,
    output logic [NUM_LINES-1:0] wake_src_o,
    output logic                 timer_wake_o,
    output logic                 xcvr_wake_o
);

    logic                 lp, bias_win, sample, fwu_due, woken;
    logic [SENS_W-1:0]    sens;
    logic [LPC_W-1:0]     lpc;
    logic [NUM_LINES-1:0] line_q;

    assign lp = mode_i[1];

    lpw_cfg_regs #(.SENS_W(SENS_W), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .lp_i(lp), .we_i(cfg_we_i),
        .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i), .sens_o(sens), .lpc_o(lpc)
    );

    lpw_timers #(.CYC_PERIOD(CYC_PERIOD), .BIAS_ON(BIAS_ON), .FWU_TIME(FWU_TIME)) u_tmr (
        .clk(clk), .rst_n(rst_n), .lp_i(lp),
        .bias_win_o(bias_win), .sample_o(sample), .fwu_due_o(fwu_due)
    );

    lpw_wake_core #(.NUM_LINES(NUM_LINES)) u_core (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lines_i(wake_lines_i),
        .xcvr_i(xcvr_wake_i), .sens_i(sens), .lpc_i(lpc), .sample_i(sample),
        .fwu_due_i(fwu_due), .woken_o(woken), .wake_src_o(wake_src_o),
        .timer_o(timer_wake_o), .xcvr_o(xcvr_wake_o),
        .supply_o(supply_en_o), .irq_o(irq_o)
    );

    // Register the raw line state for status readout.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= wake_lines_i;
    end

    assign line_state_o = line_q;
    assign sens_cfg_o   = sens;
    assign lp_cfg_o     = lpc;
    assign bias_en_o    = bias_win && !woken
                       && lpc[LPC_BIAS_BIT] && lpc[LPC_AUTO_BIT];

    assert_bias_only_cyclic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bias_en_o |-> (lp && lpc[LPC_BIAS_BIT] && lpc[LPC_AUTO_BIT]))
        else $error("bias switch driven outside cyclic low power");

endmodule

// File: tb/lp_wake_ctrl_tb.sv
module lp_wake_ctrl_tb;

    localparam int P = 16;
    localparam int B = 4;
    localparam int F = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       cfg_we_i = 1'b0, cfg_sel_i = 1'b0, xcvr_wake_i = 1'b0;
    logic [3:0] cfg_wdata_i = '0, wake_lines_i = '0;
    logic [3:0] line_state_o, sens_cfg_o, lp_cfg_o, wake_src_o;
    logic       bias_en_o, supply_en_o, irq_o, timer_wake_o, xcvr_wake_o;

    always #2 clk = ~clk;

    lp_wake_ctrl #(.NUM_PAIRS(2), .CYC_PERIOD(P), .BIAS_ON(B), .FWU_TIME(F)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .wake_lines_i(wake_lines_i), .xcvr_wake_i(xcvr_wake_i),
        .line_state_o(line_state_o), .sens_cfg_o(sens_cfg_o), .lp_cfg_o(lp_cfg_o),
        .bias_en_o(bias_en_o), .supply_en_o(supply_en_o), .irq_o(irq_o),
        .wake_src_o(wake_src_o), .timer_wake_o(timer_wake_o), .xcvr_wake_o(xcvr_wake_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    logic [3:0] m_sens = '0, m_lpc = '0, m_snap = '0, m_src = '0, m_line = '0;
    logic       m_lpq = 0, m_woken = 0, m_tf = 0, m_xf = 0, m_sup = 0, m_irq = 0;
    int         m_cyc = 0, m_fwu = 0;
    logic       last_bias;
    int         bias_hi;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_match(input logic [3:0] ln);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] c;
            c = m_sens[2*(i/2) +: 2];
            case (c)
                2'b01:   r[i] = ln[i];
                2'b10:   r[i] = !ln[i];
                2'b11:   r[i] = ln[i] != m_snap[i];
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    // One clock cycle: drive, check bias, advance model, compare outputs.
    task automatic step(input logic [1:0] md, input logic we, input logic sel,
                        input logic [3:0] wd, input logic [3:0] ln, input logic xw);
        logic in_lp, direct, cyclic, ev, lh, th, xh, eb;
        logic [3:0] mt;
        mode_i = md; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
        wake_lines_i = ln; xcvr_wake_i = xw;
        in_lp  = md[1];
        mt     = model_match(ln);
        direct = !m_lpc[3] && !m_lpc[0];
        cyclic = m_lpc[3] && m_lpc[0];
        eb     = in_lp && cyclic && !m_woken && (m_cyc < B);
        #1;
        chk(bias_en_o === eb, "R4 bias_en_o", bias_en_o, eb);
        last_bias = bias_en_o;
        ev = in_lp && m_lpq && !m_woken;
        lh = ev && (|mt) && (direct || (cyclic && m_cyc == B - 1));
        th = ev && m_lpc[1] && (m_fwu == F - 1);
        xh = ev && m_lpc[2] && xw;
        @(posedge clk);
        if (in_lp && !m_lpq) begin
            m_woken = 0; m_src = '0; m_tf = 0; m_xf = 0; m_sup = 0; m_irq = 0;
        end else if (lh || th || xh) begin
            m_woken = 1; m_src = lh ? mt : 4'h0; m_tf = th; m_xf = xh;
            m_sup = (md == 2'b10); m_irq = (md == 2'b11);
        end
        m_cyc = !in_lp ? 0 : ((m_cyc == P - 1) ? 0 : m_cyc + 1);
        m_fwu = !in_lp ? 0 : ((m_fwu == F - 1) ? m_fwu : m_fwu + 1);
        if (!in_lp) m_snap = ln;
        m_lpq = in_lp; m_line = ln;
        if (we && !in_lp) begin
            if (!sel) m_sens = wd;
            else if (!(wd[3] && wd[1] && wd[0])) m_lpc = wd;
        end
        @(negedge clk);
        chk(line_state_o === m_line, "R1 line_state_o", line_state_o, m_line);
        chk(sens_cfg_o === m_sens, "R11 sens_cfg_o", sens_cfg_o, m_sens);
        chk(lp_cfg_o === m_lpc, "R6 lp_cfg_o", lp_cfg_o, m_lpc);
        chk(supply_en_o === m_sup, "R9 supply_en_o", supply_en_o, m_sup);
        chk(irq_o === m_irq, "R9 irq_o", irq_o, m_irq);
        chk(wake_src_o === m_src, "R10 wake_src_o", wake_src_o, m_src);
        chk(timer_wake_o === m_tf, "R7 timer_wake_o", timer_wake_o, m_tf);
        chk(xcvr_wake_o === m_xf, "R8 xcvr_wake_o", xcvr_wake_o, m_xf);
    endtask

    task automatic wr(input logic sel, input logic [3:0] d, input logic [3:0] ln);
        step(2'b00, 1'b1, sel, d, ln, 1'b0);
    endtask

    task automatic idle(input logic [1:0] md, input logic [3:0] ln, input int n);
        for (int i = 0; i < n; i++) step(md, 1'b0, 1'b0, 4'h0, ln, 1'b0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk({line_state_o, sens_cfg_o, lp_cfg_o, wake_src_o} == 16'h0, "R12 reset fields",
            {line_state_o, sens_cfg_o, lp_cfg_o, wake_src_o}, 0);
        chk({bias_en_o, supply_en_o, irq_o, timer_wake_o, xcvr_wake_o} == 5'h0,
            "R12 reset flags", {bias_en_o, supply_en_o, irq_o, timer_wake_o, xcvr_wake_o}, 0);

        // R3/R2: direct mode, pair A high level, Sleep wake on line 0
        wr(1'b0, 4'b0001, 4'h0);
        wr(1'b1, 4'b0000, 4'h0);
        idle(2'b10, 4'h0, 5);
        chk(supply_en_o == 0, "R3 no wake while lines idle", supply_en_o, 0);
        // R11: writes during Sleep are ignored
        step(2'b10, 1'b1, 1'b0, 4'hF, 4'h0, 1'b0);
        chk(sens_cfg_o == 4'b0001, "R11 write in Sleep ignored", sens_cfg_o, 4'b0001);
        step(2'b10, 1'b0, 1'b0, 4'h0, 4'b0001, 1'b0);
        chk(supply_en_o == 1 && irq_o == 0, "R9 Sleep wake raises supply", supply_en_o, 1);
        chk(wake_src_o == 4'b0001, "R10 cause line 0", wake_src_o, 4'b0001);
        // R10 freeze: further activity does not alter record
        idle(2'b10, 4'b0011, 3);
        chk(wake_src_o == 4'b0001, "R10 record frozen", wake_src_o, 4'b0001);
        idle(2'b00, 4'h0, 2);

        // R2: pair B low level, Stop wake on line 3
        wr(1'b0, 4'b1000, 4'hF);
        idle(2'b11, 4'hF, 4);
        step(2'b11, 1'b0, 1'b0, 4'h0, 4'b0111, 1'b0);
        chk(irq_o == 1 && supply_en_o == 0, "R9 Stop wake raises irq", irq_o, 1);
        chk(wake_src_o == 4'b1000, "R2 pair B low level", wake_src_o, 4'b1000);
        idle(2'b00, 4'h0, 2);

        // R2: any-change against pre-entry snapshot
        wr(1'b0, 4'b0011, 4'b0001);
        idle(2'b10, 4'b0001, 4);
        chk(supply_en_o == 0, "R2 unchanged line no wake", supply_en_o, 0);
        step(2'b10, 1'b0, 1'b0, 4'h0, 4'b0011, 1'b0);
        chk(wake_src_o == 4'b0010, "R2 change on line 1", wake_src_o, 4'b0010);
        idle(2'b00, 4'h0, 2);

        // R5: one of the two sense bits only, lines ignored
        wr(1'b0, 4'b0001, 4'h0);
        wr(1'b1, 4'b1000, 4'h0);
        idle(2'b10, 4'b0001, 20);
        chk(supply_en_o == 0 && wake_src_o == 0, "R5 partial sense mode ignores lines",
            supply_en_o, 0);
        idle(2'b00, 4'h0, 2);

        // R4: cyclic sensing, line high only outside sample slot
        wr(1'b1, 4'b1001, 4'h0);
        bias_hi = 0;
        for (int k = 0; k < 2 * P; k++) begin
            step(2'b10, 1'b0, 1'b0, 4'h0, ((k % P) == B - 1) ? 4'h0 : 4'h1, 1'b0);
            if (last_bias) bias_hi++;
        end
        chk(bias_hi == 2 * B, "R4 bias cycles per two frames", bias_hi, 2 * B);
        chk(supply_en_o == 0, "R4 off-slot activity ignored", supply_en_o, 0);
        idle(2'b10, 4'h1, B);
        chk(supply_en_o == 1 && wake_src_o == 4'b0001, "R4 wake at sample slot",
            supply_en_o, 1);
        idle(2'b00, 4'h0, 2);

        // R6: exclusion in both directions
        wr(1'b1, 4'b1011, 4'h0);
        chk(lp_cfg_o == 4'b1001, "R6 forced refused while cyclic", lp_cfg_o, 4'b1001);
        wr(1'b1, 4'b0010, 4'h0);
        wr(1'b1, 4'b1011, 4'h0);
        chk(lp_cfg_o == 4'b0010, "R6 cyclic refused while forced", lp_cfg_o, 4'b0010);

        // R7: forced wake timing in Stop
        wr(1'b0, 4'b0000, 4'h0);
        idle(2'b11, 4'h0, F - 1);
        chk(irq_o == 0, "R7 not yet at F-1 cycles", irq_o, 0);
        idle(2'b11, 4'h0, 1);
        chk(irq_o == 1 && timer_wake_o == 1, "R7 forced wake", timer_wake_o, 1);
        idle(2'b00, 4'h0, 2);

        // R8: transceiver wake ignored when disabled, taken when enabled
        wr(1'b1, 4'b0000, 4'h0);
        idle(2'b10, 4'h0, 2);
        step(2'b10, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1);
        chk(xcvr_wake_o == 0 && supply_en_o == 0, "R8 disabled pulse ignored",
            xcvr_wake_o, 0);
        idle(2'b00, 4'h0, 2);
        wr(1'b1, 4'b0100, 4'h0);
        idle(2'b10, 4'h0, 2);
        step(2'b10, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1);
        chk(xcvr_wake_o == 1 && supply_en_o == 1 && wake_src_o == 0, "R8 pulse wakes",
            xcvr_wake_o, 1);
        idle(2'b00, 4'h0, 2);

        // Random episodes checked against the model
        for (int ep = 0; ep < 40; ep++) begin
            logic [3:0] ln;
            ln = 4'($urandom());
            wr(1'b0, 4'($urandom()), ln);
            wr(1'b1, 4'($urandom()), ln);
            idle(2'b00 | 2'($urandom() % 2), ln, 2);
            for (int c = 0; c < 55; c++) begin
                for (int b = 0; b < 4; b++)
                    if ($urandom() % 20 == 0) ln[b] = !ln[b];
                step(2'b10 | 2'($urandom() % 2) & {1'b1, (c == 0) ? 1'($urandom()) : mode_i[0]},
                     1'($urandom() % 8 == 0), 1'($urandom()), 4'($urandom()), ln,
                     1'($urandom() % 50 == 0));
            end
            idle(2'b00, ln, 3);
        end
        summary();
    end

endmodule